// File: doc/BRIEF.md
# Bitfield Clear and Insert Unit

This unit rewrites a contiguous run of bits inside a 32-bit destination word. In clear mode the selected run is forced to zero. In insert mode the run is overwritten with the lowest bits of a source word. The run is described at run time by a start position and a width. Every bit outside the run keeps its destination value.

A caller presents one request per cycle, together with an input-valid strobe. The result appears one clock later on a registered output stage, with a valid strobe. The unit also checks each request. A width of zero, a run that extends past bit 31, or a register index that names the stack pointer (13) or the program counter (15) raises an illegal flag. In that case the destination word passes through unmodified. The unit never produces condition flags.

Top module: `bitfield_merge_unit`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, `out_valid`, `out_bad` and `out_word` are all zero.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and it is low at all other times.
- R3: With `op_insert` = 0 (clear), bits `fld_start` through `fld_start+fld_width-1` of `out_word` are zero and every other bit equals `dst_val`. Clear never sets a bit that was zero in `dst_val`.
- R4: With `op_insert` = 1 (insert), bits `fld_start+k` of `out_word` equal `src_val[k]` for each k from 0 to `fld_width-1`, and every other bit equals `dst_val`.
- R5: A width of 32 with a start of 0 covers the whole word. Clear then gives all zeros, and insert gives `src_val` unchanged.
- R6: If `fld_width` is 0, or if `fld_start + fld_width` is greater than 32, then `out_bad` is 1 and `out_word` equals `dst_val`.
- R7: If `dst_idx` is 13 or 15, then `out_bad` is 1 and `out_word` equals `dst_val`, whatever the operation.
- R8: If `src_idx` is 13 or 15, insert raises `out_bad` and returns `dst_val`. For clear, `src_idx` is ignored: the result stays legal and is computed normally.
- R9: In a cycle without `in_valid`, `out_word` and `out_bad` keep the values they held before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_insert | input | 1 | 0 = clear the field, 1 = insert the source bits |
| dst_idx | input | 4 | Register index of the destination operand |
| src_idx | input | 4 | Register index of the source operand |
| dst_val | input | 32 | Destination word |
| src_val | input | 32 | Source word |
| fld_start | input | 5 | Lowest bit position of the field |
| fld_width | input | 6 | Number of bits in the field |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_word | output | 32 | Merged result word |
| out_bad | output | 1 | Illegal request flag |

## Verification
Every result is due exactly one clock after its request. A request is driven on a falling edge and captured on the next rising edge. Outputs are read on the falling edge that follows, half a period after that capture, so no check depends on the order of processes at an edge. The hold checks take this further: they keep `in_valid` low and change every other input, then sample on each later falling edge, which confirms that nothing moves until the next strobe.

// File: rtl/bitfield_merge_unit.sv
module bitfield_merge_unit #(
  parameter int DW     = 32,
  parameter int IDX_W  = 4,
  parameter int SP_IDX = 13,
  parameter int PC_IDX = 15
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     op_insert,
  input  logic [IDX_W-1:0]         dst_idx,
  input  logic [IDX_W-1:0]         src_idx,
  input  logic [DW-1:0]            dst_val,
  input  logic [DW-1:0]            src_val,
  input  logic [$clog2(DW)-1:0]    fld_start,
  input  logic [$clog2(DW):0]      fld_width,
  output logic                     out_valid,
  output logic [DW-1:0]            out_word,
  output logic                     out_bad
);

  localparam int POS_W = $clog2(DW);
  localparam int WID_W = POS_W + 1;
  localparam int SUM_W = WID_W + 1;
  localparam logic [WID_W-1:0] FULL_W  = WID_W'(DW);
  localparam logic [SUM_W-1:0] LIMIT   = SUM_W'(DW);
  localparam logic [IDX_W-1:0] SP_CODE = IDX_W'(SP_IDX);
  localparam logic [IDX_W-1:0] PC_CODE = IDX_W'(PC_IDX);

  logic [DW-1:0]    low_ones;
  logic [DW-1:0]    mask;
  logic [DW-1:0]    placed;
  logic [DW-1:0]    merged;
  logic [DW-1:0]    next_word;
  logic [SUM_W-1:0] span;
  logic             range_bad;
  logic             dst_reserved;
  logic             src_reserved;
  logic             bad;

  assign low_ones  = (fld_width >= FULL_W) ? '1 : ((DW'(1) << fld_width) - DW'(1));
  assign mask      = low_ones << fld_start;
  assign placed    = (src_val << fld_start) & mask;
  assign merged    = (dst_val & ~mask) | (op_insert ? placed : '0);

  assign span      = SUM_W'(fld_start) + SUM_W'(fld_width);
  assign range_bad = (fld_width == '0) || (span > LIMIT);

  assign dst_reserved = (dst_idx == SP_CODE) || (dst_idx == PC_CODE);
  assign src_reserved = op_insert && ((src_idx == SP_CODE) || (src_idx == PC_CODE));
  assign bad          = range_bad || dst_reserved || src_reserved;

  assign next_word = bad ? dst_val : merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bad   <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= next_word;
        out_bad  <= bad;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_CLEAR_SETS_NOTHING: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_insert) |=> ((out_word & ~$past(dst_val)) == '0)); // R3
  AST_ZERO_WIDTH_PASSES: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fld_width == '0) |=> (out_bad && out_word == $past(dst_val))); // R6
  AST_DST_RESERVED_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (dst_idx == SP_CODE || dst_idx == PC_CODE)) |=> (out_bad && out_word == $past(dst_val))); // R7
  AST_SRC_RESERVED_INSERT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_insert && (src_idx == SP_CODE || src_idx == PC_CODE)) |=> out_bad); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_word) && $stable(out_bad))); // R9

endmodule

// File: tb/bitfield_merge_unit_bench.sv
module bitfield_merge_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        op_insert = 1'b0;
  logic [3:0]  dst_idx = '0;
  logic [3:0]  src_idx = '0;
  logic [31:0] dst_val = '0;
  logic [31:0] src_val = '0;
  logic [4:0]  fld_start = '0;
  logic [5:0]  fld_width = '0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_bad;

  int vectors = 0;
  int misses  = 0;

  always #5 clk = ~clk;

  bitfield_merge_unit u_bitfield_merge_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_insert(op_insert),
    .dst_idx(dst_idx), .src_idx(src_idx), .dst_val(dst_val), .src_val(src_val),
    .fld_start(fld_start), .fld_width(fld_width),
    .out_valid(out_valid), .out_word(out_word), .out_bad(out_bad)
  );

  function automatic logic [31:0] ref_word(input logic ins, input logic [31:0] d,
                                           input logic [31:0] s, input int lsb, input int w);
    logic [31:0] r;
    r = d;
    for (int i = 0; i < 32; i++)
      if (i >= lsb && i < lsb + w) r[i] = ins ? s[i - lsb] : 1'b0;
    return r;
  endfunction

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic ins, input logic [3:0] di, input logic [3:0] si,
                       input logic [31:0] d, input logic [31:0] s, input int lsb, input int w,
                       input logic exp_bad);
    logic [31:0] exp;
    @(negedge clk);
    in_valid = 1'b1; op_insert = ins; dst_idx = di; src_idx = si;
    dst_val = d; src_val = s; fld_start = 5'(lsb); fld_width = 6'(w);
    @(negedge clk);
    in_valid = 1'b0;
    exp = exp_bad ? d : ref_word(ins, d, s, lsb, w);
    cmp({req, " valid"}, 32'(out_valid), 32'd1);
    cmp({req, " bad"}, 32'(out_bad), 32'(exp_bad));
    cmp({req, " word"}, out_word, exp);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R1 valid", 32'(out_valid), 32'd0);
    cmp("R1 bad", 32'(out_bad), 32'd0);
    cmp("R1 word", out_word, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 after release", {30'd0, out_valid, out_bad}, 32'd0);
  endtask

  task automatic t_example;
    apply("R3 example", 1'b0, 4'd4, 4'd2, 32'hFFFF_FFFF, 32'h0, 8, 12, 1'b0);
    cmp("R3 example value", out_word, 32'hFFF0_00FF);
    apply("R4 example", 1'b1, 4'd9, 4'd2, 32'h1234_5678, 32'h0000_0ABC, 8, 12, 1'b0);
    cmp("R4 example value", out_word, 32'h123A_BC78);
  endtask

  task automatic t_sweep;
    for (int lsb = 0; lsb < 32; lsb++)
      for (int w = 1; w <= 32 - lsb; w++) begin
        apply("R3 sweep", 1'b0, 4'($urandom_range(0, 12)), 4'($urandom_range(0, 12)),
              $urandom, $urandom, lsb, w, 1'b0);
        apply("R4 sweep", 1'b1, 4'($urandom_range(0, 12)), 4'($urandom_range(0, 12)),
              $urandom, $urandom, lsb, w, 1'b0);
      end
  endtask

  task automatic t_full;
    apply("R5 clear", 1'b0, 4'd1, 4'd2, 32'hDEAD_BEEF, 32'h5555_AAAA, 0, 32, 1'b0);
    cmp("R5 clear zero", out_word, 32'h0);
    apply("R5 insert", 1'b1, 4'd1, 4'd2, 32'hDEAD_BEEF, 32'h5555_AAAA, 0, 32, 1'b0);
    cmp("R5 insert copy", out_word, 32'h5555_AAAA);
  endtask

  task automatic t_range_bad;
    apply("R6 width0", 1'b1, 4'd0, 4'd1, 32'hCAFE_F00D, 32'hFFFF_FFFF, 4, 0, 1'b1);
    apply("R6 overrun", 1'b0, 4'd0, 4'd1, 32'hCAFE_F00D, 32'h0, 31, 2, 1'b1);
    apply("R6 wide", 1'b1, 4'd0, 4'd1, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 1, 32, 1'b1);
    apply("R6 max", 1'b1, 4'd0, 4'd1, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 31, 63, 1'b1);
    apply("R6 edge legal", 1'b1, 4'd0, 4'd1, 32'h0000_0000, 32'hFFFF_FFFF, 31, 1, 1'b0);
  endtask

  task automatic t_reserved;
    apply("R7 dst sp clear", 1'b0, 4'd13, 4'd1, 32'h8765_4321, 32'h0, 0, 8, 1'b1);
    apply("R7 dst pc insert", 1'b1, 4'd15, 4'd1, 32'h8765_4321, 32'hFFFF_FFFF, 4, 8, 1'b1);
    apply("R7 dst 14 legal", 1'b0, 4'd14, 4'd1, 32'h8765_4321, 32'h0, 4, 8, 1'b0);
    apply("R8 src sp insert", 1'b1, 4'd3, 4'd13, 32'h1111_1111, 32'hFFFF_FFFF, 0, 16, 1'b1);
    apply("R8 src pc insert", 1'b1, 4'd3, 4'd15, 32'h1111_1111, 32'hFFFF_FFFF, 8, 8, 1'b1);
    apply("R8 src pc clear ignored", 1'b0, 4'd3, 4'd15, 32'hFFFF_FFFF, 32'h0, 8, 8, 1'b0);
    apply("R8 src sp clear ignored", 1'b0, 4'd3, 4'd13, 32'hFFFF_FFFF, 32'h0, 0, 4, 1'b0);
  endtask

  task automatic t_hold;
    logic [31:0] kept;
    apply("R9 seed", 1'b1, 4'd0, 4'd15, 32'hA5A5_A5A5, 32'h0, 0, 4, 1'b1);
    kept = out_word;
    for (int k = 0; k < 3; k++) begin
      op_insert = 1'b1; dst_idx = 4'd2; src_idx = 4'd3;
      dst_val = $urandom; src_val = $urandom; fld_start = 5'(k); fld_width = 6'd4;
      @(negedge clk);
      cmp("R2 idle valid", 32'(out_valid), 32'd0);
      cmp("R9 idle word", out_word, kept);
      cmp("R9 idle bad", 32'(out_bad), 32'd1);
    end
  endtask

  initial begin
    #2_000_000;
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    t_reset();
    t_example();
    t_full();
    t_range_bad();
    t_reserved();
    t_hold();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule